// File: doc/BRIEF.md
# Delayed Up/Down Debounce Filter

This block cleans one asynchronous digital input. It brings the raw input into the clock domain, then compares each sample with the present filtered level on the cycles where a filter-rate enable strobe is high. A mismatch adds one to a 16-bit timer. A match either subtracts one from the timer or returns it to zero, depending on a mode input. When the timer reaches the programmed threshold, the filtered level flips, a one-clock trigger pulse is produced and the timer goes back to zero. A pulse or glitch that is shorter than the threshold in filter ticks therefore never reaches the output.

Two sticky flags report rejected activity. One is set by a rising input edge and one by a falling input edge, but only while the timer holds a partial count, above zero and below the threshold. Each flag has its own clear input. A threshold of zero turns off filtering: the level then follows the synchronized sample on every clock, and the trigger pulses on every change.

Top module: `dbf_filter`

## Requirements
- R1: With the enable held high and a nonzero threshold N, a clean input step changes `level` exactly N+2 clocks after the input changes: two synchronizer stages, then N mismatching ticks. Each mismatching tick adds one to the timer, and the tick that brings it to N flips `level` and clears the timer.
- R2: The timer and `level` change only in response to clocks on which `tick` was high. With `tick` held low and a nonzero threshold, `level` does not move.
- R3: With `zero_on_match` = 0, each matching tick subtracts one from a nonzero timer, so mismatch periods separated by short gaps add up.
- R4: With `zero_on_match` = 1, any matching tick sets the timer to zero, so only an unbroken run of N mismatching ticks flips `level`.
- R5: `trig` is high for exactly the clock cycle in which `level` takes a new value, and is low on every other cycle.
- R6: `glitch_rise` is set when the synchronized input rises while the timer is above zero and below the threshold.
- R7: `glitch_fall` is set when the synchronized input falls while the timer is above zero and below the threshold.
- R8: A glitch flag stays set until its clear input (`clr_rise` or `clr_fall`) is high. If a set condition and a clear happen in the same cycle, the flag is set.
- R9: With a threshold of zero, `level` follows the synchronized input three clocks after an input change, `trig` pulses on each change, and the timer stays at zero.
- R10: While `rst` is high and after its release, `level`, `trig`, `glitch_rise` and `glitch_fall` are all low and the timer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Filter-rate enable strobe, one system clock wide |
| din | input | 1 | Raw asynchronous input |
| thr | input | TW (16) | Threshold in filter ticks; zero selects bypass |
| zero_on_match | input | 1 | 1: a matching tick clears the timer; 0: a matching tick subtracts one |
| clr_rise | input | 1 | Clears the rising-edge glitch flag |
| clr_fall | input | 1 | Clears the falling-edge glitch flag |
| level | output | 1 | Filtered level output |
| trig | output | 1 | One-clock pulse whenever `level` changes |
| glitch_rise | output | 1 | Sticky flag: a rising edge was rejected |
| glitch_fall | output | 1 | Sticky flag: a falling edge was rejected |

## Verification
The input patterns are single pulses of width N-1, N and longer than N. They separate "long enough to pass" from "just too short". Patterns of two pulses with a low gap between them separate the decrement mode from the clear-on-match mode: the same pattern passes in one mode and is rejected in the other. Zero-threshold pulses confirm that filtering is off. Exact step latency measurements show that the flip happens on the Nth tick and not one tick later, and a gated enable shows that the count advances only on ticks. The expected flag values for each pattern follow where the edges fall relative to a partial count, so an edge seen at a zero timer can be told apart from one seen mid-count.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // What the timer does on a given clock
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_UP,
    ACT_DOWN,
    ACT_ZERO,
    ACT_FIRE
  } tmr_act_e;

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dbf_timer.sv
module dbf_timer
  import dbf_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          smp,
  input  logic          level,
  input  logic [TW-1:0] thr,
  input  logic          zero_on_match,
  output logic [TW-1:0] timer_q,
  output logic          fire,
  output logic          bypass
);

  localparam logic [TW-1:0] ONE  = TW'(1);
  localparam logic [TW-1:0] ZERO = '0;

  tmr_act_e      act;
  logic [TW-1:0] up_val;

  assign bypass = (thr == ZERO);
  assign up_val = timer_q + ONE;

  always_comb begin
    act = ACT_HOLD;
    if (bypass) begin
      act = ACT_ZERO;
    end else if (tick) begin
      if (smp != level) begin
        act = (up_val == thr) ? ACT_FIRE : ACT_UP;
      end else if (zero_on_match) begin
        act = ACT_ZERO;
      end else if (timer_q != ZERO) begin
        act = ACT_DOWN;
      end
    end
  end

  assign fire = (act == ACT_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= ZERO;
    end else begin
      case (act)
        ACT_UP:   timer_q <= up_val;
        ACT_DOWN: timer_q <= timer_q - ONE;
        ACT_ZERO,
        ACT_FIRE: timer_q <= ZERO;
        default:  timer_q <= timer_q;
      endcase
    end
  end

endmodule

// File: rtl/dbf_glitch.sv
module dbf_glitch #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp,
  input  logic [TW-1:0] timer_q,
  input  logic [TW-1:0] thr,
  input  logic          clr_rise,
  input  logic          clr_fall,
  output logic          flag_rise,
  output logic          flag_fall
);

  logic smp_prev;
  logic in_window;
  logic rise_ev;
  logic fall_ev;

  assign in_window = (timer_q != '0) && (timer_q < thr);
  assign rise_ev   = smp & ~smp_prev & in_window;
  assign fall_ev   = ~smp & smp_prev & in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_prev  <= 1'b0;
      flag_rise <= 1'b0;
      flag_fall <= 1'b0;
    end else begin
      smp_prev <= smp;
      if (rise_ev)       flag_rise <= 1'b1;
      else if (clr_rise) flag_rise <= 1'b0;
      if (fall_ev)       flag_fall <= 1'b1;
      else if (clr_fall) flag_fall <= 1'b0;
    end
  end

endmodule

// File: rtl/dbf_filter.sv
module dbf_filter #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          din,
  input  logic [TW-1:0] thr,
  input  logic          zero_on_match,
  input  logic          clr_rise,
  input  logic          clr_fall,
  output logic          level,
  output logic          trig,
  output logic          glitch_rise,
  output logic          glitch_fall
);

  logic          smp;
  logic [TW-1:0] timer_q;
  logic          fire;
  logic          bypass;

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (smp)
  );

  dbf_timer #(.TW(TW)) u_timer (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .smp           (smp),
    .level         (level),
    .thr           (thr),
    .zero_on_match (zero_on_match),
    .timer_q       (timer_q),
    .fire          (fire),
    .bypass        (bypass)
  );

  dbf_glitch #(.TW(TW)) u_glitch (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp),
    .timer_q   (timer_q),
    .thr       (thr),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .flag_rise (glitch_rise),
    .flag_fall (glitch_fall)
  );

  // Registered level and trigger outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      trig  <= 1'b0;
    end else if (bypass) begin
      level <= smp;
      trig  <= (smp != level);
    end else begin
      level <= level ^ fire;
      trig  <= fire;
    end
  end

endmodule

// File: rtl/dbf_filter_chk.sv
module dbf_filter_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [TW-1:0] thr,
  input logic [TW-1:0] timer_q,
  input logic          clr_rise,
  input logic          clr_fall,
  input logic          level,
  input logic          trig,
  input logic          glitch_rise,
  input logic          glitch_fall
);

  // R5: a trigger only accompanies a level change
  a_r5_trig_means_change: assert property (@(posedge clk) disable iff (rst)
    trig |-> (level != $past(level)));

  // R5: every level change carries a trigger
  a_r5_change_means_trig: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> trig);

  // R2: with a nonzero threshold, no tick means no level movement
  a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (thr != '0 && $past(thr) != '0 && !$past(tick)) |-> $stable(level));

  // R1: the timer never reaches the threshold while the threshold is steady
  a_r1_timer_below_thr: assert property (@(posedge clk) disable iff (rst)
    (thr != '0 && $past(thr) == thr && $past(timer_q) < thr) |-> (timer_q < thr));

  // R9: in bypass the timer sits at zero
  a_r9_bypass_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(thr) == '0) |-> (timer_q == '0));

  // R8: flags are sticky without a clear
  a_r8_rise_sticky: assert property (@(posedge clk) disable iff (rst)
    (glitch_rise && !clr_rise) |=> glitch_rise);
  a_r8_fall_sticky: assert property (@(posedge clk) disable iff (rst)
    (glitch_fall && !clr_fall) |=> glitch_fall);

  // R10: reset clears outputs and timer
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!level && !trig && !glitch_rise && !glitch_fall && timer_q == '0));

endmodule

bind dbf_filter dbf_filter_chk #(.TW(TW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .thr         (thr),
  .timer_q     (timer_q),
  .clr_rise    (clr_rise),
  .clr_fall    (clr_fall),
  .level       (level),
  .trig        (trig),
  .glitch_rise (glitch_rise),
  .glitch_fall (glitch_fall)
);

// File: tb/sim_dbf_filter.sv
module sim_dbf_filter;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic          din = 1'b0;
  logic [TW-1:0] thr = '0;
  logic          zmode = 1'b0;
  logic          clr_r = 1'b0;
  logic          clr_f = 1'b0;
  logic          level, trig, g_rise, g_fall;

  int n_chk  = 0;
  int n_fail = 0;
  int trig_cnt;

  always #2.5 clk = ~clk;

  dbf_filter #(.TW(TW)) u0 (
    .clk (clk), .rst (rst), .tick (tick), .din (din), .thr (thr),
    .zero_on_match (zmode), .clr_rise (clr_r), .clr_fall (clr_f),
    .level (level), .trig (trig), .glitch_rise (g_rise), .glitch_fall (g_fall)
  );

  // thr, mode, high a, low b, high c, toggles, rise flag, fall flag
  typedef struct packed {
    logic [15:0] thr;
    logic        zm;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  c;
    logic [3:0]  tog;
    logic        er;
    logic        ef;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'd4,  1'b0, 8'd4,  8'd0, 8'd0, 4'd2, 1'b0, 1'b0}, // R1 exact width passes
    '{16'd4,  1'b0, 8'd3,  8'd0, 8'd0, 4'd0, 1'b0, 1'b1}, // R1 R7 one short
    '{16'd1,  1'b0, 8'd1,  8'd0, 8'd0, 4'd2, 1'b0, 1'b0}, // R1 minimum
    '{16'd0,  1'b0, 8'd1,  8'd0, 8'd0, 4'd2, 1'b0, 1'b0}, // R9 bypass
    '{16'd0,  1'b1, 8'd5,  8'd0, 8'd0, 4'd2, 1'b0, 1'b0}, // R9 bypass
    '{16'd6,  1'b0, 8'd4,  8'd1, 8'd3, 4'd2, 1'b1, 1'b1}, // R3 R6 accumulate
    '{16'd6,  1'b1, 8'd4,  8'd1, 8'd3, 4'd0, 1'b0, 1'b1}, // R4 reset on match
    '{16'd6,  1'b0, 8'd4,  8'd3, 8'd3, 4'd0, 1'b1, 1'b1}, // R3 R6 gap too long
    '{16'd5,  1'b1, 8'd5,  8'd0, 8'd0, 4'd2, 1'b0, 1'b0}, // R4 unbroken run
    '{16'd16, 1'b0, 8'd20, 8'd0, 8'd0, 4'd2, 1'b0, 1'b0}  // R1 long pulse
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig) trig_cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din = 1'b0; clr_r = 1'b0; clr_f = 1'b0; tick = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(3);
    trig_cnt = 0;
  endtask

  initial begin
    #500000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    trig_cnt = 0;
    // R10: reset state
    cyc(3);
    chk(level == 0 && trig == 0 && g_rise == 0 && g_fall == 0, "R10 reset outputs",
        {level, trig, g_rise, g_fall}, 0);
    rst = 1'b0;
    cyc(4);
    chk(level == 0 && trig == 0, "R10 after release", {level, trig}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      thr = VECS[v].thr; zmode = VECS[v].zm;
      do_reset();
      din = 1'b1; cyc(VECS[v].a);
      if (VECS[v].b != 0) begin din = 1'b0; cyc(VECS[v].b); end
      if (VECS[v].c != 0) begin din = 1'b1; cyc(VECS[v].c); end
      din = 1'b0;
      cyc(2 * int'(VECS[v].thr) + 20);
      chk(trig_cnt == int'(VECS[v].tog), $sformatf("R1/R3/R4/R5/R9 vec%0d toggles", v),
          trig_cnt, VECS[v].tog);
      chk(level == 0, $sformatf("R1 vec%0d settle", v), level, 0);
      chk(g_rise == VECS[v].er, $sformatf("R6 vec%0d rise flag", v), g_rise, VECS[v].er);
      chk(g_fall == VECS[v].ef, $sformatf("R7 vec%0d fall flag", v), g_fall, VECS[v].ef);
    end

    // R1 exact latency, R5 trigger width
    begin
      int lat;
      thr = 16'd5; zmode = 1'b0;
      do_reset();
      din = 1'b1; lat = 0;
      while (!level && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == 7, "R1 step latency", lat, 7);
      chk(trig == 1, "R5 trig with change", trig, 1);
      @(negedge clk);
      chk(trig == 0, "R5 trig one cycle", trig, 0);

      // R9 bypass latency
      thr = '0;
      do_reset();
      din = 1'b1; lat = 0;
      while (!level && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == 3, "R9 bypass latency", lat, 3);
      chk(trig == 1, "R9 bypass trig", trig, 1);
    end

    // R2 enable gating
    thr = 16'd2; zmode = 1'b0;
    do_reset();
    tick = 1'b0; din = 1'b1;
    cyc(20);
    chk(level == 0, "R2 no tick holds level", level, 0);
    for (int i = 0; i < 4; i++) begin tick = (i == 0); cyc(1); end
    chk(level == 0, "R2 one tick not enough", level, 0);
    for (int i = 0; i < 40; i++) begin tick = (i % 4 == 0); cyc(1); end
    chk(level == 1, "R2 ticks advance", level, 1);
    tick = 1'b1;

    // R8 sticky then clear
    thr = 16'd4; zmode = 1'b0;
    do_reset();
    din = 1'b1; cyc(3); din = 1'b0; cyc(30);
    chk(g_fall == 1, "R8 flag sticky", g_fall, 1);
    clr_f = 1'b1; cyc(1); clr_f = 1'b0;
    chk(g_fall == 0, "R8 flag cleared", g_fall, 0);

    // R8 set wins over a held clear
    begin
      int hi;
      do_reset();
      clr_f = 1'b1; hi = 0;
      din = 1'b1; cyc(3); din = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (g_fall) hi++; end
      clr_f = 1'b0;
      chk(hi == 1, "R8 set beats clear", hi, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule